// File: doc/BRIEF.md
# SDRAM One-Shot Command Initiator

This block sits in the control path of an SDRAM controller. Software sets up one SDRAM block by writing a small control register. That register holds two arm bits, one for precharge-all and one for load-mode-register, together with a data-width field and a field that selects where the command line sits in the address. When an arm bit is set and the next access that qualifies arrives on the CPU bus, the block takes that access. It does not hand the access to the normal transfer path. Instead it drives one special command onto the SDRAM command pins, taking the address pins from the access address. It then acknowledges the bus cycle and clears the arm bit.

Software uses the block during memory bring-up. It writes the register with precharge-all armed and performs one write to the SDRAM range. It then arms load-mode-register and performs one access whose address carries the mode value. Any access that does not qualify is passed on through `fwdReq` to the normal read/write machinery, which lies outside this block.

Top module: `sdram_oneshot_cmd`

## Requirements
- R1: After reset the command pins are idle (`sdCsN`, `sdRasN`, `sdCasN`, `sdWeN` all 1), `sdAddr` and `sdBank` are 0, `busAck` is 0 and `regRdData` is 0.
- R2: Register layout: bit 0 arms precharge-all, bit 1 arms load-mode, bits 3:2 hold the width code, bits 6:4 hold the mux selection n, and bit 7 always reads 0. Writing 1 to an arm bit sets it. Writing 0 to an arm bit leaves it unchanged. The field bits take the written value.
- R3: `portBytes` decodes the width code: 00 gives 4, 01 gives 1, and 10 or 11 gives 2.
- R4: With load-mode armed, the next access, read or write, is taken. In the cycle after the accepting edge the pins are `sdCsN`=0, `sdRasN`=0, `sdCasN`=0, `sdWeN`=0, and `sdAddr` equals the access address.
- R5: Precharge-all fires only on a write. A read with only precharge-all armed is forwarded and issues no command. On a write the pins are `sdCsN`=0, `sdRasN`=0, `sdCasN`=1, `sdWeN`=0, and `sdAddr` is the access address with bit 17+n forced to 1.
- R6: During either command, `sdBank` equals the access address bits starting at 18+n, for every n from 0 to 7.
- R7: A taken access drives the command pins for exactly one cycle, then raises `busAck` for exactly one cycle. This puts the acknowledge in the second cycle after the accepting edge.
- R8: The arm bit of the issued command reads 0 from the acknowledge cycle onward. The other arm bit is untouched.
- R9: If both arm bits are set, a write issues precharge-all only. The next access then issues load-mode. Each access issues at most one command.
- R10: When no arm bit qualifies, `fwdReq` follows `busReq`, no command is driven and `busAck` stays 0. While a command is in progress, `fwdReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| busReq | input | 1 | CPU access to this SDRAM block, held until acknowledged |
| busWrite | input | 1 | Access direction, 1 = write |
| busAddr | input | ADDR_W | Access address |
| busAck | output | 1 | Acknowledge of a taken access |
| fwdReq | output | 1 | Access handed to the normal transfer path |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| sdAddr | output | ADDR_W | SDRAM address pins during a command |
| sdBank | output | BANK_W | SDRAM bank select during a command |
| portBytes | output | 3 | Decoded data width in bytes |

## Verification
The bench drives inputs on falling edges. `fwdReq` is combinational, so it is sampled 1 ns after the request is raised, before any clock edge. The command pins, `sdAddr` and `sdBank` come from a single register and are sampled at the first falling edge after the accepting edge. `busAck` and the cleared arm bit are sampled at the second falling edge. `busAck` is sampled once more at the third falling edge to confirm it has already dropped. Register fields and `portBytes` become visible one edge after the write strobe, and they are read at the falling edge that follows.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  // command selected for a taken access
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PALL = 2'd1,
    CMD_MRS  = 2'd2
  } cmdKindT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic    fire;  // accept edge: load pins for the command
    cmdKindT kind;  // which command is loaded
    logic    done;  // command cycle ends: return pins to idle
  } cmdStrobeT;

  // control register bit positions
  localparam int ARM_PALL_BIT = 0;
  localparam int ARM_MRS_BIT  = 1;
  localparam int WIDTH_LSB    = 2;
  localparam int MUX_LSB      = 4;
  localparam int REG_W        = 8;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] pinCode(input cmdKindT k);
    case (k)
      CMD_PALL: pinCode = 3'b010;
      CMD_MRS:  pinCode = 3'b000;
      default:  pinCode = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int MUX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 busReq,
  input  logic                 busWrite,
  output logic                 busAck,
  output logic                 fwdReq,
  output cmdStrobeT            strobe,
  output logic [MUX_W-1:0]     muxSel,
  output logic [1:0]           widthSel
);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ACK} stateT;

  stateT   state;
  cmdKindT heldKind;
  cmdKindT pickKind;
  logic    pallArm;
  logic    mrsArm;
  logic    pallHit;
  logic    mrsHit;
  logic    accept;
  logic    clrPall;
  logic    clrMrs;
  logic    unusedRsvd;

  assign unusedRsvd = regWrData[REG_W-1];

  // precharge-all needs a write; load-mode takes any access
  always_comb begin
    pallHit  = pallArm && busWrite;
    mrsHit   = mrsArm;
    if (pallHit)     pickKind = CMD_PALL;
    else if (mrsHit) pickKind = CMD_MRS;
    else             pickKind = CMD_NONE;
    accept   = busReq && (state == ST_IDLE) && (pickKind != CMD_NONE);
    fwdReq   = busReq && (state == ST_IDLE) && (pickKind == CMD_NONE);
    clrPall  = (state == ST_CMD) && (heldKind == CMD_PALL);
    clrMrs   = (state == ST_CMD) && (heldKind == CMD_MRS);
  end

  always_comb begin
    strobe.fire = accept;
    strobe.kind = pickKind;
    strobe.done = (state == ST_CMD);
  end

  assign busAck = (state == ST_ACK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      heldKind <= CMD_NONE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_CMD;
          heldKind <= pickKind;
        end
        ST_CMD:  state <= ST_ACK;
        default: begin
          state    <= ST_IDLE;
          heldKind <= CMD_NONE;
        end
      endcase
    end
  end

  // arm bits: set by writing 1, cleared only by command completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pallArm  <= 1'b0;
      mrsArm   <= 1'b0;
      muxSel   <= '0;
      widthSel <= '0;
    end else begin
      pallArm <= (pallArm && !clrPall) || (regWrEn && regWrData[ARM_PALL_BIT]);
      mrsArm  <= (mrsArm && !clrMrs)   || (regWrEn && regWrData[ARM_MRS_BIT]);
      if (regWrEn) begin
        widthSel <= regWrData[WIDTH_LSB +: 2];
        muxSel   <= regWrData[MUX_LSB +: MUX_W];
      end
    end
  end

  always_comb begin
    regRdData                  = '0;
    regRdData[ARM_PALL_BIT]    = pallArm;
    regRdData[ARM_MRS_BIT]     = mrsArm;
    regRdData[WIDTH_LSB +: 2]  = widthSel;
    regRdData[MUX_LSB +: MUX_W] = muxSel;
  end

endmodule

// File: rtl/sdcmd_dpath.sv
module sdcmd_dpath
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BANK_W   = 2,
  parameter int MUX_W    = 3,
  parameter int CMD_BASE = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobeT         strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [MUX_W-1:0]  muxSel,
  input  logic [1:0]        widthSel,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic [2:0]        portBytes
);

  localparam int POS_W = $clog2(ADDR_W) + 1;

  logic [POS_W-1:0]  cmdPos;
  logic [ADDR_W-1:0] cmdMask;
  logic [ADDR_W-1:0] addrNext;
  logic [BANK_W-1:0] bankNext;

  assign cmdPos  = POS_W'(CMD_BASE) + POS_W'(muxSel);
  assign cmdMask = ADDR_W'(1) << cmdPos;

  // bank bits start one above the command bit
  for (genvar g = 0; g < BANK_W; g++) begin : gBank
    logic [POS_W-1:0] idx;
    assign idx         = cmdPos + POS_W'(g + 1);
    assign bankNext[g] = busAddr[idx];
  end

  assign addrNext = (strobe.kind == CMD_PALL) ? (busAddr | cmdMask) : busAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCsN                    <= 1'b1;
      {sdRasN, sdCasN, sdWeN}  <= 3'b111;
      sdAddr                   <= '0;
      sdBank                   <= '0;
    end else if (strobe.fire) begin
      sdCsN                    <= 1'b0;
      {sdRasN, sdCasN, sdWeN}  <= pinCode(strobe.kind);
      sdAddr                   <= addrNext;
      sdBank                   <= bankNext;
    end else if (strobe.done) begin
      sdCsN                    <= 1'b1;
      {sdRasN, sdCasN, sdWeN}  <= 3'b111;
      sdAddr                   <= '0;
      sdBank                   <= '0;
    end
  end

  always_comb begin
    casez (widthSel)
      2'b00:   portBytes = 3'd4;
      2'b01:   portBytes = 3'd1;
      default: portBytes = 3'd2;
    endcase
  end

endmodule

// File: rtl/sdram_oneshot_cmd.sv
module sdram_oneshot_cmd
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BANK_W   = 2,
  parameter int MUX_W    = 3,
  parameter int CMD_BASE = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output logic              fwdReq,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic [2:0]        portBytes
);

  cmdStrobeT        strobe;
  logic [MUX_W-1:0] muxSel;
  logic [1:0]       widthSel;

  sdcmd_ctrl #(.MUX_W(MUX_W)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busReq    (busReq),
    .busWrite  (busWrite),
    .busAck    (busAck),
    .fwdReq    (fwdReq),
    .strobe    (strobe),
    .muxSel    (muxSel),
    .widthSel  (widthSel)
  );

  sdcmd_dpath #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .MUX_W    (MUX_W),
    .CMD_BASE (CMD_BASE)
  ) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busAddr   (busAddr),
    .muxSel    (muxSel),
    .widthSel  (widthSel),
    .sdCsN     (sdCsN),
    .sdRasN    (sdRasN),
    .sdCasN    (sdCasN),
    .sdWeN     (sdWeN),
    .sdAddr    (sdAddr),
    .sdBank    (sdBank),
    .portBytes (portBytes)
  );

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
  parameter int ADDR_W   = 32,
  parameter int CMD_BASE = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        regRdData,
  input logic              busWrite,
  input logic              busAck,
  input logic              fwdReq,
  input logic              sdCsN,
  input logic              sdCasN,
  input logic [ADDR_W-1:0] sdAddr
);

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !sdCsN |=> sdCsN);  // R7
  AST_CMD_THEN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !sdCsN |=> busAck);  // R7
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);  // R7
  AST_PALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && sdCasN) |-> $past(busWrite));  // R5
  AST_PALL_CMD_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && sdCasN) |-> sdAddr[CMD_BASE + int'(regRdData[6:4])]);  // R5
  AST_PALL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && $past(!sdCsN && sdCasN)) |-> !regRdData[0]);  // R8
  AST_MRS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && $past(!sdCsN && !sdCasN)) |-> !regRdData[1]);  // R8
  AST_NO_FWD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN || busAck) |-> !fwdReq);  // R10

endmodule

bind sdram_oneshot_cmd sdcmd_checker #(.ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdData (regRdData),
  .busWrite  (busWrite),
  .busAck    (busAck),
  .fwdReq    (fwdReq),
  .sdCsN     (sdCsN),
  .sdCasN    (sdCasN),
  .sdAddr    (sdAddr)
);

// File: tb/sdram_oneshot_cmd_test.sv
`timescale 1ns/1ps
module sdram_oneshot_cmd_test;

  localparam int ADDR_W = 32;
  localparam int BANK_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [7:0]        regWrData = '0;
  logic [7:0]        regRdData;
  logic              busReq = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busAck;
  logic              fwdReq;
  logic              sdCsN, sdRasN, sdCasN, sdWeN;
  logic [ADDR_W-1:0] sdAddr;
  logic [BANK_W-1:0] sdBank;
  logic [2:0]        portBytes;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // captured results of one access
  logic [3:0]        cPins;
  logic [ADDR_W-1:0] cAddr;
  logic [BANK_W-1:0] cBank;
  logic              cFwd, cAckEarly, cAck, cAckLate, cCsAfter;
  logic [7:0]        cReg;

  always #4 clk = ~clk;

  sdram_oneshot_cmd uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runAccess(input logic wr, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a;
    #1 cFwd = fwdReq;
    @(negedge clk);
    cPins = {sdCsN, sdRasN, sdCasN, sdWeN};
    cAddr = sdAddr; cBank = sdBank; cAckEarly = busAck;
    @(negedge clk);
    cAck = busAck; cCsAfter = sdCsN; cReg = regRdData;
    busReq = 1'b0;
    @(negedge clk);
    cAckLate = busAck;
  endtask

  function automatic logic [BANK_W-1:0] expBank(input logic [ADDR_W-1:0] a, input int n);
    return BANK_W'(a >> (18 + n));
  endfunction

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {28'd0, sdCsN, sdRasN, sdCasN, sdWeN}, 32'hF);
    check("R1 addr", sdAddr, 0);
    check("R1 bank", {30'd0, sdBank}, 0);
    check("R1 ack", {31'd0, busAck}, 0);
    check("R1 reg", {24'd0, regRdData}, 0);

    // R3 width decode sweep, R2 field readback with reserved bit written
    for (int w = 0; w < 4; w++) begin
      regWrite(8'h80 | 8'(w << 2) | 8'(w << 4));
      check("R3 width", {29'd0, portBytes}, (w == 0) ? 4 : (w == 1) ? 1 : 2);
      check("R2 readback", {24'd0, regRdData}, (w << 2) | (w << 4));
    end

    // R10 plain access with nothing armed
    runAccess(1'b1, 32'h0123_4567);
    check("R10 fwd", {31'd0, cFwd}, 1);
    check("R10 no cmd", {28'd0, cPins}, 4'hF);
    check("R10 no ack", {30'd0, cAck, cAckEarly}, 0);

    for (int n = 0; n < 8; n++) begin
      logic [ADDR_W-1:0] a;
      a = (32'h0A5C_3E71 ^ (n * 32'h0111_1111)) & ~(32'd1 << (17 + n));
      // arm precharge-all, width code 01
      regWrite(8'(n << 4) | 8'h05);
      // R5 read does not fire it
      runAccess(1'b0, a);
      check("R5 read fwd", {31'd0, cFwd}, 1);
      check("R5 read no cmd", {28'd0, cPins}, 4'hF);
      // R5 write fires it
      runAccess(1'b1, a);
      check("R5 fwd low", {31'd0, cFwd}, 0);
      check("R5 pins", {28'd0, cPins}, 4'b0010);
      check("R5 addr", cAddr, a | (32'd1 << (17 + n)));
      check("R6 bank pall", {30'd0, cBank}, {30'd0, expBank(a, n)});
      check("R7 ack timing", {29'd0, cAckEarly, cAck, cAckLate}, 3'b010);
      check("R7 pins idle", {31'd0, cCsAfter}, 1);
      check("R8 pall clear", {24'd0, cReg}, (n << 4) | 4);

      // arm load-mode, then write 0 to it: stays set
      regWrite(8'(n << 4) | 8'h02);
      regWrite(8'(n << 4));
      check("R2 zero no effect", {24'd0, regRdData}, (n << 4) | 2);
      a = 32'h1F2E_3D4C ^ (n * 32'h0203_0405);
      runAccess(n[0], a);
      check("R4 pins", {28'd0, cPins}, 4'b0000);
      check("R4 addr", cAddr, a);
      check("R6 bank mrs", {30'd0, cBank}, {30'd0, expBank(a, n)});
      check("R8 mrs clear", {24'd0, cReg}, n << 4);
    end

    // R9 priority with both armed
    regWrite(8'h33);
    runAccess(1'b1, 32'h0000_1234);
    check("R9 pall first", {28'd0, cPins}, 4'b0010);
    check("R9 mrs kept", {24'd0, cReg}, 8'h32);
    runAccess(1'b0, 32'h0000_5678);
    check("R9 mrs next", {28'd0, cPins}, 4'b0000);
    check("R9 all clear", {24'd0, cReg}, 8'h30);
    runAccess(1'b1, 32'h0000_9ABC);
    check("R9 one each", {28'd0, cPins}, 4'hF);

    finish();
  end

endmodule